// File: doc/BRIEF.md
# Serial Peripheral Slave Byte Engine

This block is the receive and transmit engine of a byte-wide SPI slave. It runs on the system clock. The serial clock, the serial data input and the active-low select each pass through a synchronizer, and the block finds the serial clock edges inside the system clock domain. It never produces a clock of its own. Software loads the next outgoing byte through a write port. It reads the last received byte from a buffer register. A sticky completion flag marks each finished byte.

A configuration word sets the behaviour. It holds an enable bit, the idle level of the serial clock, which clock edge samples the input, and a 4-bit mode field. Mode `0100` turns on select control: the select line gates shifting, gates the data output and restarts framing. Mode `0101` shifts whenever the block is enabled and does not look at the select line. The data output is modelled as a value plus an output enable, so the pad is not part of the block.

Top module: `spis_slave`

## Requirements
- R1: After reset, `done_flag`, `wcol_flag`, `ovf_flag`, `miso_oe` and `rd_data` are all 0.
- R2: A byte written through `wr_data` while no byte is in progress is sent most significant bit first. Bit 7 is on `miso_out` before the first sampling edge.
- R3: When the eighth input bit is sampled, the received byte (first bit in bit 7) goes to `rd_data` if the buffer has been read, and `done_flag` is set.
- R4: With `edge_sel`=0, the input is sampled on the active-to-idle clock transition and the output changes on the idle-to-active transition. With `edge_sel`=1 the two roles are swapped.
- R5: `idle_hi`=0 makes 0 the idle level of the serial clock, and `idle_hi`=1 makes 1 the idle level. Transfers work correctly with either level.
- R6: In mode `0100`, serial clock edges that arrive while `ss_n_in` is high shift nothing and complete no byte, and `miso_oe` is 0.
- R7: In mode `0100`, `miso_oe` drops in the same cycle that `ss_n_in` rises, even partway through a byte.
- R8: A rise of select (mode `0100`) or a clear of `en` throws away a partial byte. The next byte is then framed from its first bit.
- R9: In mode `0101`, the select line is ignored and bytes transfer with `ss_n_in` held high.
- R10: With `edge_sel`=1 and a mode other than `0100`, no bit is captured, `done_flag` stays 0 and `miso_oe` stays 0.
- R11: A write while a byte is in progress sets `wcol_flag` and is discarded, so the byte already in progress goes out unchanged.
- R12: If a byte completes while the buffer still holds an unread byte, `ovf_flag` is set and `rd_data` keeps the older byte. A pulse on `rd_en` marks the buffer as read.
- R13: A pulse on `clr_flags` clears `done_flag`, `wcol_flag` and `ovf_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Module enable; 0 also clears the bit counter |
| idle_hi | input | 1 | Idle level of the serial clock |
| edge_sel | input | 1 | 0: sample on return to idle; 1: sample on leaving idle |
| mode | input | 4 | 0100 select-controlled, 0101 select ignored |
| wr_en | input | 1 | Load the transmit byte |
| wr_data | input | DATA_W | Byte to transmit |
| rd_en | input | 1 | Mark the receive buffer as read |
| clr_flags | input | 1 | Clear the completion, collision and overflow flags |
| sclk_in | input | 1 | External serial clock, asynchronous |
| mosi_in | input | 1 | Serial data in, asynchronous |
| ss_n_in | input | 1 | Active-low select, asynchronous |
| rd_data | output | DATA_W | Receive buffer |
| miso_out | output | 1 | Serial data out value |
| miso_oe | output | 1 | Serial data out enable |
| done_flag | output | 1 | Byte completion flag |
| wcol_flag | output | 1 | Write collision flag |
| ovf_flag | output | 1 | Receive overflow flag |

## Verification
A bit counter that is wrong shows up as a completion flag that is early or late, and as a received byte rotated by one or more places. Both are visible as soon as the first whole byte finishes after an aborted one. A wrong choice of edge or polarity changes the bit order of the returned transmit byte within the same frame. A buffer update that should have been blocked shows on `rd_data` right after the byte that overflowed it. The output enable is combinational from the raw select pin, so it is checked one time unit after the select rises, not a cycle later.

// File: rtl/spis_pkg.sv
package spis_pkg;

    localparam logic [3:0] MODE_SEL  = 4'b0100;
    localparam logic [3:0] MODE_FREE = 4'b0101;

    typedef struct packed {
        logic       en;
        logic       idle_hi;
        logic       edge_sel;
        logic [3:0] mode;
    } spis_cfg_t;

    typedef struct packed {
        logic lead;
        logic trail;
    } spis_edge_t;

    function automatic logic mode_known(input logic [3:0] m);
        return (m == MODE_SEL) || (m == MODE_FREE);
    endfunction

    function automatic logic sel_ctrl(input logic [3:0] m);
        return m == MODE_SEL;
    endfunction

    // Sampling on the leading edge needs the select line to mark the frame start.
    function automatic logic framing_ok(input spis_cfg_t c);
        return !c.edge_sel || sel_ctrl(c.mode);
    endfunction

endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
    parameter int               W       = 3,
    parameter int               STAGES  = 2,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stage[i] <= RST_VAL;
                else if (i == 0) stage[i] <= d;
                else stage[i] <= stage[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/spis_edge.sv
module spis_edge
    import spis_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lvl,
    input  logic       idle_hi,
    output spis_edge_t edges
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= lvl;
    end

    always_comb begin
        edges.lead  = (lvl != prev) && (lvl != idle_hi);
        edges.trail = (lvl != prev) && (lvl == idle_hi);
    end
endmodule

// File: rtl/spis_core.sv
module spis_core
    import spis_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  spis_cfg_t         cfg,
    input  logic              ss_act,
    input  logic              mosi_s,
    input  spis_edge_t        edges,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              clr_flags,
    output logic [DATA_W-1:0] rx_buf,
    output logic              dout,
    output logic              done,
    output logic              wcol,
    output logic              ovf
);
    localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

    logic [CW-1:0]     cnt;
    logic [DATA_W-1:0] sr;
    logic              full;
    logic              gate, abort, samp, chg, busy, shift_now, complete, load_ok;

    always_comb begin
        gate      = cfg.en && mode_known(cfg.mode) && framing_ok(cfg)
                    && (!sel_ctrl(cfg.mode) || ss_act);
        abort     = !cfg.en || (sel_ctrl(cfg.mode) && !ss_act);
        samp      = cfg.edge_sel ? edges.lead  : edges.trail;
        chg       = cfg.edge_sel ? edges.trail : edges.lead;
        busy      = (cnt != '0);
        shift_now = gate && samp;
        complete  = shift_now && (cnt == LAST);
        load_ok   = wr_en && !busy && !shift_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            sr     <= '0;
            dout   <= 1'b0;
            rx_buf <= '0;
            full   <= 1'b0;
            done   <= 1'b0;
            wcol   <= 1'b0;
            ovf    <= 1'b0;
        end else begin
            if (abort)                   cnt <= '0;
            else if (shift_now)          cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;

            if (shift_now)               sr <= {sr[DATA_W-2:0], mosi_s};
            else if (load_ok)            sr <= wr_data;

            if (load_ok)                 dout <= wr_data[DATA_W-1];
            else if (gate && chg)        dout <= sr[DATA_W-1];

            if (clr_flags) begin
                done <= 1'b0;
                wcol <= 1'b0;
                ovf  <= 1'b0;
            end
            if (rd_en) full <= 1'b0;

            if (wr_en && busy) wcol <= 1'b1;

            if (complete) begin
                done <= 1'b1;
                if (full && !rd_en) ovf <= 1'b1;
                else begin
                    rx_buf <= {sr[DATA_W-2:0], mosi_s};
                    full   <= 1'b1;
                end
            end
        end
    end

    AST_ABORT_CLEARS_COUNT: assert property (@(posedge clk) disable iff (rst)
        abort |=> (cnt == '0)); // R8
    AST_DONE_ON_LAST_BIT: assert property (@(posedge clk) disable iff (rst)
        complete |=> done); // R3
    AST_OVF_KEEPS_BUFFER: assert property (@(posedge clk) disable iff (rst)
        (complete && full && !rd_en) |=> ($stable(rx_buf) && ovf)); // R12
    AST_WCOL_ON_BUSY_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && busy) |=> wcol); // R11
    AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (!gate && !wr_en) |=> $stable(sr)); // R6
    AST_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr_flags && !complete && !wr_en) |=> (!done && !wcol && !ovf)); // R13
endmodule

// File: rtl/spis_slave.sv
module spis_slave
    import spis_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              idle_hi,
    input  logic              edge_sel,
    input  logic [3:0]        mode,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              clr_flags,
    input  logic              sclk_in,
    input  logic              mosi_in,
    input  logic              ss_n_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              miso_out,
    output logic              miso_oe,
    output logic              done_flag,
    output logic              wcol_flag,
    output logic              ovf_flag
);
    spis_cfg_t  cfg;
    spis_edge_t edges;
    logic [2:0] pins_s;

    assign cfg = '{en: en, idle_hi: idle_hi, edge_sel: edge_sel, mode: mode};

    // Bit order: {ss_n, mosi, sclk}; select resets to its inactive level.
    spis_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ss_n_in, mosi_in, sclk_in}),
        .q   (pins_s)
    );

    spis_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .lvl     (pins_s[0]),
        .idle_hi (cfg.idle_hi),
        .edges   (edges)
    );

    spis_core #(.DATA_W(DATA_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .ss_act    (!pins_s[2]),
        .mosi_s    (pins_s[1]),
        .edges     (edges),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .clr_flags (clr_flags),
        .rx_buf    (rd_data),
        .dout      (miso_out),
        .done      (done_flag),
        .wcol      (wcol_flag),
        .ovf       (ovf_flag)
    );

    // Release follows the raw pin at once; assertion waits for the synchronized select.
    always_comb begin
        miso_oe = cfg.en && mode_known(cfg.mode) && framing_ok(cfg)
                  && (!sel_ctrl(cfg.mode) || (!ss_n_in && !pins_s[2]));
    end

    AST_OE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
        (sel_ctrl(mode) && ss_n_in) |-> !miso_oe); // R7
endmodule

// File: tb/sim_spis_slave.sv
module sim_spis_slave;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0, idle_hi = 1'b0, edge_sel = 1'b0;
    logic [3:0] mode = 4'b0100;
    logic       wr_en = 1'b0, rd_en = 1'b0, clr_flags = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       sclk_in = 1'b0, mosi_in = 1'b0, ss_n_in = 1'b1;
    logic [7:0] rd_data;
    logic       miso_out, miso_oe, done_flag, wcol_flag, ovf_flag;

    int checks = 0;
    int fails  = 0;
    localparam int H = 5;

    always #2 clk = ~clk;

    spis_slave u0 (
        .clk(clk), .rst(rst), .en(en), .idle_hi(idle_hi), .edge_sel(edge_sel),
        .mode(mode), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .clr_flags(clr_flags), .sclk_in(sclk_in), .mosi_in(mosi_in),
        .ss_n_in(ss_n_in), .rd_data(rd_data), .miso_out(miso_out),
        .miso_oe(miso_oe), .done_flag(done_flag), .wcol_flag(wcol_flag),
        .ovf_flag(ovf_flag)
    );

    // {idle_hi, edge_sel, mode, tx byte, rx byte}
    localparam logic [21:0] VEC [0:5] = '{
        {1'b0, 1'b0, 4'b0100, 8'hA5, 8'h3C},
        {1'b1, 1'b0, 4'b0100, 8'h81, 8'h7E},
        {1'b0, 1'b1, 4'b0100, 8'h5A, 8'hC3},
        {1'b1, 1'b1, 4'b0100, 8'hF0, 8'h0F},
        {1'b0, 1'b0, 4'b0101, 8'h69, 8'h96},
        {1'b1, 1'b0, 4'b0101, 8'h01, 8'h80}
    };

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic ih, input logic es, input logic [3:0] md);
        @(negedge clk);
        en = 1'b0;
        sclk_in = ih;
        wait_clk(6);
        idle_hi = ih; edge_sel = es; mode = md;
        en = 1'b1;
        wait_clk(2);
    endtask

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk); wr_en = 1'b1; wr_data = b;
        @(negedge clk); wr_en = 1'b0;
        wait_clk(1);
    endtask

    task automatic pulse_rd();
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); clr_flags = 1'b1;
        @(negedge clk); clr_flags = 1'b0;
    endtask

    task automatic one_bit(input logic b, output logic o);
        mosi_in = b;
        wait_clk(2);
        if (!edge_sel) begin
            sclk_in = ~idle_hi; wait_clk(H);
            o = miso_out;
            sclk_in = idle_hi;  wait_clk(H);
        end else begin
            o = miso_out;
            sclk_in = ~idle_hi; wait_clk(H);
            sclk_in = idle_hi;  wait_clk(H);
        end
    endtask

    task automatic xfer(input logic [7:0] rx, output logic [7:0] got);
        for (int i = 7; i >= 0; i--) begin
            logic o;
            one_bit(rx[i], o);
            got[i] = o;
        end
    endtask

    task automatic select(input logic active);
        @(negedge clk); ss_n_in = !active;
        wait_clk(4);
    endtask

    initial begin
        #700000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] got;
        logic       o;
        wait_clk(4);
        rst = 1'b0;
        wait_clk(2);
        // R1 reset state
        chk("R1 done", done_flag, 0);
        chk("R1 wcol", wcol_flag, 0);
        chk("R1 ovf", ovf_flag, 0);
        chk("R1 oe", miso_oe, 0);
        chk("R1 rd_data", rd_data, 0);

        // Table: R2 R3 R4 R5 R9 across polarity, edge and mode
        for (int v = 0; v < 6; v++) begin
            logic [21:0] e;
            e = VEC[v];
            set_cfg(e[21], e[20], e[19:16]);
            select(e[19:16] == 4'b0100);
            write_byte(e[15:8]);
            xfer(e[7:0], got);
            wait_clk(4);
            chk($sformatf("R2/R4/R5 tx vec%0d", v), got, e[15:8]);
            chk($sformatf("R3 rx vec%0d", v), rd_data, e[7:0]);
            chk($sformatf("R3 done vec%0d", v), done_flag, 1);
            if (e[19:16] == 4'b0101)
                chk($sformatf("R9 oe with ss high vec%0d", v), miso_oe, 1);
            select(1'b0);
            pulse_rd();
            pulse_clr();
        end

        // R6: select high in mode 0100 blocks shifting
        set_cfg(1'b0, 1'b0, 4'b0100);
        select(1'b0);
        chk("R6 oe off", miso_oe, 0);
        xfer(8'hFF, got);
        wait_clk(4);
        chk("R6 no done", done_flag, 0);
        chk("R6 rd_data kept", rd_data, 8'h80);

        // R7 / R8: select rises partway through a byte
        select(1'b1);
        write_byte(8'hA5);
        for (int i = 0; i < 3; i++) one_bit(1'b1, o);
        @(negedge clk); ss_n_in = 1'b1;
        #1;
        chk("R7 oe drops at once", miso_oe, 0);
        wait_clk(4);
        chk("R8 no done after abort", done_flag, 0);
        select(1'b1);
        write_byte(8'h96);
        xfer(8'h3C, got);
        wait_clk(4);
        chk("R8 tx after select abort", got, 8'h96);
        chk("R8 rx after select abort", rd_data, 8'h3C);
        pulse_rd(); pulse_clr();

        // R8: enable cleared partway through a byte
        for (int i = 0; i < 3; i++) one_bit(1'b0, o);
        @(negedge clk); en = 1'b0;
        wait_clk(3);
        en = 1'b1;
        wait_clk(2);
        write_byte(8'h55);
        xfer(8'hAA, got);
        wait_clk(4);
        chk("R8 rx after enable abort", rd_data, 8'hAA);
        chk("R8 tx after enable abort", got, 8'h55);
        pulse_rd(); pulse_clr();

        // R11: write during a byte is discarded
        write_byte(8'h12);
        for (int i = 7; i >= 5; i--) begin one_bit(1'b1, o); got[i] = o; end
        write_byte(8'h34);
        chk("R11 wcol set", wcol_flag, 1);
        for (int i = 4; i >= 0; i--) begin one_bit(1'b0, o); got[i] = o; end
        wait_clk(4);
        chk("R11 byte unchanged", got, 8'h12);
        chk("R11 rx", rd_data, 8'hE0);

        // R12: second byte without read
        write_byte(8'h00);
        xfer(8'h77, got);
        wait_clk(4);
        chk("R12 ovf set", ovf_flag, 1);
        chk("R12 buffer kept", rd_data, 8'hE0);

        // R13: flags cleared
        pulse_clr();
        wait_clk(1);
        chk("R13 done clr", done_flag, 0);
        chk("R13 wcol clr", wcol_flag, 0);
        chk("R13 ovf clr", ovf_flag, 0);
        pulse_rd();
        select(1'b0);

        // R10: leading-edge sampling without select control
        set_cfg(1'b0, 1'b1, 4'b0101);
        chk("R10 oe off", miso_oe, 0);
        xfer(8'h5C, got);
        wait_clk(4);
        chk("R10 no done", done_flag, 0);
        chk("R10 rd_data kept", rd_data, 8'hE0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule